// File: doc/BRIEF.md
# Byte/Word Switchable ROM Read Port

This block is a read-only memory read port holding 2 Mbit of fixed contents. The contents are computed from the address by a fixed arithmetic function, so no initialisation file is needed. A mode input selects the view of the contents. In word mode the port returns 16-bit words, one per word address. In byte mode it returns 8-bit bytes, and one extra low-order address input picks the half of the addressed word. That extra input shares its position with data bit 15. In byte mode, bit 15 is therefore never driven by the port.

Outputs are modelled the way tri-state pads are driven inside a chip: a data bus plus a per-bit drive-enable vector. A pin whose enable bit is zero is at high impedance. Three enables gate the outputs: an active-low chip enable, an active-low output enable, and a second output enable. The second output enable has a polarity fixed at build time, and one build setting ignores it.

Access delay is a fixed number of clock cycles. A valid strobe rises when that delay has run out since the last change of the selected location.

Top module: `rom_rdport`

## Requirements
- R1: In word mode (`word_mode_i` = 1), `data_o` carries the full 16-bit word W(A) for word address A, and `data_oe_o` is 16'hFFFF when the outputs are enabled.
- R2: In byte mode (`word_mode_i` = 0), `data_o[7:0]` is W(A)[7:0] when `a_lsb_i` = 0 and W(A)[15:8] when `a_lsb_i` = 1. `data_o[15:8]` is zero.
- R3: In byte mode, `data_oe_o` is 16'h00FF when the outputs are enabled. Bits 8 to 15 are undriven, and bit 15 serves as the low address input.
- R4: The outputs are enabled only when `ce_n_i` = 0, `oe_n_i` = 0 and the second enable is active. If any of these is not met at a clock edge, then after that edge `data_oe_o` = 0, `data_o` = 0 and `valid_o` = 0.
- R5: Parameter OE2_MODE sets the polarity of `oe2_i`: 0 means active-high, 1 means active-low, and 2 means the input is ignored and treated as always active.
- R6: A change of address, mode or (in byte mode) `a_lsb_i` is sampled at edge t. `valid_o` is 0 after edges t to t+LATENCY-1. It is 1 after edge t+LATENCY if the outputs are enabled.
- R7: In word mode, `a_lsb_i` has no effect: toggling it changes neither `data_o` nor `valid_o`.
- R8: While `valid_o` stays 1 on consecutive cycles, `data_o` does not change.
- R9: During and right after reset, `data_o`, `data_oe_o` and `valid_o` are all zero.
- R10: The contents are W(A) = ((A*40503 + 12345) mod 65536) XOR (floor(A/2) mod 65536), for the 17-bit word address A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Word address |
| word_mode_i | input | 1 | 1 selects word mode, 0 selects byte mode |
| a_lsb_i | input | 1 | Byte select within the word, used in byte mode only (shares bit-15 position) |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| oe2_i | input | 1 | Second output enable, polarity set by OE2_MODE |
| data_o | output | 16 | Read data |
| data_oe_o | output | 16 | Per-bit drive enable (0 = high impedance) |
| valid_o | output | 1 | Read data stable and outputs enabled |

## Verification
Some properties are checked by assertions on every cycle:
- Any dropped enable empties the drive vector and data on the next cycle.
- The drive vector only ever takes its word or byte shape.
- The upper byte is zero whenever only the lower byte is driven.
- A sampled location change always pulls the strobe low.
- Data holds still while the strobe stays high.
- With the ignore setting, the second enable never gates the outputs.

Other behaviour needs the bench's scenarios, since it depends on values computed outside the design:
- The content values themselves, and which byte each select value returns.
- The exact cycle the strobe rises.
- That the byte select is ignored in word mode.
- How each polarity setting treats the second enable.

These scenarios run near-exhaustive sweeps at both ends of the address space.

// File: rtl/rom_rdport_pkg.sv
package rom_rdport_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = WORD_W / 2;

    localparam int OE2_ACT_HIGH = 0;
    localparam int OE2_ACT_LOW  = 1;
    localparam int OE2_IGNORE   = 2;

    // Fixed content function: multiplicative hash folded with a shifted copy
    function automatic logic [WORD_W-1:0] rom_word(input logic [31:0] a);
        logic [31:0] prod;
        logic [31:0] shr;
        prod = a * 32'd40503 + 32'd12345;
        shr  = a >> 1;
        return prod[WORD_W-1:0] ^ shr[WORD_W-1:0];
    endfunction

endpackage

// File: rtl/rom_addr_stage.sv
module rom_addr_stage #(
    parameter int ADDR_W  = 17,
    parameter int LATENCY = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              word_mode_i,
    input  logic              lsb_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              word_mode_o,
    output logic              lsb_o,
    output logic              ready_o
);
    localparam int CW = $clog2(LATENCY + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(LATENCY);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              word;
        logic              lsb;
        logic [CW-1:0]     cnt;
    } stage_t;

    stage_t st_d, st_q;
    logic   chg;

    always_comb begin
        st_d      = st_q;
        st_d.addr = addr_i;
        st_d.word = word_mode_i;
        // the byte select only names a location in byte mode
        st_d.lsb  = word_mode_i ? 1'b0 : lsb_i;
        chg = (st_d.addr != st_q.addr) || (st_d.word != st_q.word) ||
              (st_d.lsb != st_q.lsb);
        if (chg) begin
            st_d.cnt = CNT_LOAD;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.addr <= '0;
            st_q.word <= 1'b0;
            st_q.lsb  <= 1'b0;
            st_q.cnt  <= CNT_LOAD;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o      = st_q.addr;
    assign word_mode_o = st_q.word;
    assign lsb_o       = st_q.lsb;
    assign ready_o     = (st_q.cnt == '0);

    // R6: a sampled location change always restarts the access delay
    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> !ready_o);

    // R7: in word mode the registered byte select never moves
    a_r7_lsb_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        word_mode_o |-> !lsb_o);

endmodule

// File: rtl/rom_out_sel.sv
module rom_out_sel
    import rom_rdport_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              word_mode_i,
    input  logic              lsb_i,
    input  logic              ready_i,
    input  logic              en_i,
    output logic [WORD_W-1:0] data_o,
    output logic [WORD_W-1:0] data_oe_o,
    output logic              valid_o
);
    localparam logic [WORD_W-1:0] OE_WORD = '1;
    localparam logic [WORD_W-1:0] OE_BYTE = {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [WORD_W-1:0] oe;
        logic              en;
    } out_t;

    out_t              o_d, o_q;
    logic [WORD_W-1:0] word_val;
    logic [BYTE_W-1:0] byte_val;

    always_comb begin
        word_val = rom_word(32'(addr_i));
        byte_val = lsb_i ? word_val[WORD_W-1:BYTE_W] : word_val[BYTE_W-1:0];
        o_d      = o_q;
        o_d.en   = en_i;
        if (!en_i) begin
            o_d.data = '0;
            o_d.oe   = '0;
        end else if (word_mode_i) begin
            o_d.data = word_val;
            o_d.oe   = OE_WORD;
        end else begin
            o_d.data = {{BYTE_W{1'b0}}, byte_val};
            o_d.oe   = OE_BYTE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign data_o    = o_q.data;
    assign data_oe_o = o_q.oe;
    assign valid_o   = o_q.en & ready_i;

    // R4: a dropped enable clears drive and data after the next edge
    a_r4_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (data_oe_o == '0) && (data_o == '0) && !valid_o);

    // R3: drive vector is either empty, the byte shape or the word shape
    a_r3_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe_o == '0) || (data_oe_o == OE_WORD) || (data_oe_o == OE_BYTE));

    // R2: with only the low byte driven, the upper data bits are zero
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe_o == OE_BYTE) |-> (data_o[WORD_W-1:BYTE_W] == '0));

    // R8: data holds while the strobe stays high
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o)) |-> $stable(data_o));

endmodule

// File: rtl/rom_rdport.sv
module rom_rdport
    import rom_rdport_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int LATENCY  = 3,
    parameter int OE2_MODE = OE2_ACT_LOW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              word_mode_i,
    input  logic              a_lsb_i,
    input  logic              ce_n_i,
    input  logic              oe_n_i,
    input  logic              oe2_i,
    output logic [15:0]       data_o,
    output logic [15:0]       data_oe_o,
    output logic              valid_o
);
    logic              oe2_act;
    logic              out_en;
    logic [ADDR_W-1:0] s_addr;
    logic              s_word;
    logic              s_lsb;
    logic              s_ready;

    generate
        if (OE2_MODE == OE2_ACT_HIGH) begin : g_oe2_high
            assign oe2_act = oe2_i;
        end else if (OE2_MODE == OE2_ACT_LOW) begin : g_oe2_low
            assign oe2_act = ~oe2_i;
        end else begin : g_oe2_ignore
            assign oe2_act = oe2_i | 1'b1;
            // R5: with the ignore setting the second enable never gates output
            a_r5_ignored: assert property (@(posedge clk) disable iff (!rst_n)
                (!ce_n_i && !oe_n_i) |=> (data_oe_o != '0));
        end
    endgenerate

    assign out_en = ~ce_n_i & ~oe_n_i & oe2_act;

    rom_addr_stage #(
        .ADDR_W  (ADDR_W),
        .LATENCY (LATENCY)
    ) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_i      (addr_i),
        .word_mode_i (word_mode_i),
        .lsb_i       (a_lsb_i),
        .addr_o      (s_addr),
        .word_mode_o (s_word),
        .lsb_o       (s_lsb),
        .ready_o     (s_ready)
    );

    rom_out_sel #(
        .ADDR_W (ADDR_W)
    ) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_i      (s_addr),
        .word_mode_i (s_word),
        .lsb_i       (s_lsb),
        .ready_i     (s_ready),
        .en_i        (out_en),
        .data_o      (data_o),
        .data_oe_o   (data_oe_o),
        .valid_o     (valid_o)
    );

endmodule

// File: tb/sim_rom_rdport.sv
module sim_rom_rdport;
    localparam int AW  = 17;
    localparam int LAT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          wmode = 1'b0, lsb = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, oe2 = 1'b1;
    logic [15:0]   d0, d1, d2, e0, e1, e2;
    logic          v0, v1, v2;
    int            n_cmp = 0, n_bad = 0;

    always #5 clk = ~clk;

    rom_rdport #(.ADDR_W(AW), .LATENCY(LAT), .OE2_MODE(1)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .word_mode_i(wmode),
        .a_lsb_i(lsb), .ce_n_i(ce_n), .oe_n_i(oe_n), .oe2_i(oe2),
        .data_o(d0), .data_oe_o(e0), .valid_o(v0));
    rom_rdport #(.ADDR_W(AW), .LATENCY(LAT), .OE2_MODE(0)) u1 (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .word_mode_i(wmode),
        .a_lsb_i(lsb), .ce_n_i(ce_n), .oe_n_i(oe_n), .oe2_i(oe2),
        .data_o(d1), .data_oe_o(e1), .valid_o(v1));
    rom_rdport #(.ADDR_W(AW), .LATENCY(LAT), .OE2_MODE(2)) u2 (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .word_mode_i(wmode),
        .a_lsb_i(lsb), .ce_n_i(ce_n), .oe_n_i(oe_n), .oe2_i(oe2),
        .data_o(d2), .data_oe_o(e2), .valid_o(v2));

    function automatic logic [15:0] w_of(input int a);
        int p;
        p = (a * 40503 + 12345) % 65536;
        return 16'(p) ^ 16'((a / 2) % 65536);
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // one read: apply a new location, check the strobe timing and the result
    task automatic access(input int a, input logic wm, input logic ls);
        logic [15:0] w, exp_d;
        @(negedge clk);
        addr = AW'(a); wmode = wm; lsb = ls;
        @(negedge clk);
        chk("R6 strobe low after change", 16'(v0), 16'h0);
        repeat (LAT - 1) @(negedge clk);
        chk("R6 strobe low before delay ends", 16'(v0), 16'h0);
        @(negedge clk);
        chk("R6 strobe high after delay", 16'(v0), 16'h1);
        w = w_of(a);
        if (wm) exp_d = w;
        else    exp_d = {8'h00, ls ? w[15:8] : w[7:0]};
        chk(wm ? "R1 R10 word data" : "R2 R10 byte data", d0, exp_d);
        chk(wm ? "R1 word drive" : "R3 byte drive", e0, wm ? 16'hFFFF : 16'h00FF);
        chk("R5 active-high unit off", e1, 16'h0000);
        chk("R5 ignore unit data", d2, exp_d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9 data in reset", d0, 16'h0);
        chk("R9 drive in reset", e0, 16'h0);
        chk("R9 strobe in reset", 16'(v0), 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 drive after reset", e0, 16'h0);
        chk("R9 strobe after reset", 16'(v0), 16'h0);

        ce_n = 1'b0; oe_n = 1'b0; oe2 = 1'b0;

        // R1, R10: word sweeps at both ends of the space
        for (int a = 1; a < 200; a++) access(a, 1'b1, 1'b0);
        for (int a = 131072 - 200; a < 131072; a++) access(a, 1'b1, 1'b0);
        // R2, R3: byte sweeps, byte address = {word address, select}
        for (int b = 0; b < 400; b++) access(b / 2, 1'b0, 1'(b % 2));
        for (int b = 262144 - 400; b < 262144; b++) access(b / 2, 1'b0, 1'(b % 2));

        // R7: select toggled in word mode changes nothing
        access(777, 1'b1, 1'b0);
        @(negedge clk); lsb = 1'b1;
        @(negedge clk);
        chk("R7 strobe held", 16'(v0), 16'h1);
        chk("R7 data held", d0, w_of(777));
        repeat (3) @(negedge clk);
        chk("R8 data stable while valid", d0, w_of(777));
        chk("R8 strobe stays", 16'(v0), 16'h1);
        lsb = 1'b0;

        // R4: each enable withdrawn in turn
        @(negedge clk); ce_n = 1'b1;
        @(negedge clk);
        chk("R4 chip enable off drive", e0, 16'h0);
        chk("R4 chip enable off data", d0, 16'h0);
        chk("R4 chip enable off strobe", 16'(v0), 16'h0);
        chk("R4 chip enable off ignore unit", e2, 16'h0);
        ce_n = 1'b0;
        @(negedge clk);
        chk("R4 re-enabled drive", e0, 16'hFFFF);
        chk("R4 re-enabled data", d0, w_of(777));
        oe_n = 1'b1;
        @(negedge clk);
        chk("R4 output enable off drive", e0, 16'h0);
        chk("R4 output enable off strobe", 16'(v0), 16'h0);
        oe_n = 1'b0;

        // R5: second enable polarity per build setting
        oe2 = 1'b1;
        @(negedge clk);
        chk("R5 active-low unit off", e0, 16'h0);
        chk("R5 active-high unit on", e1, 16'hFFFF);
        chk("R5 active-high unit data", d1, w_of(777));
        chk("R5 ignore unit on", e2, 16'hFFFF);
        oe2 = 1'b0;
        @(negedge clk);
        chk("R5 active-low unit on", e0, 16'hFFFF);
        chk("R5 active-high unit off again", e1, 16'h0);
        chk("R5 ignore unit still on", e2, 16'hFFFF);

        // R6: mode switch alone restarts the delay, R3 shape follows
        access(777, 1'b0, 1'b1);
        chk("R3 byte drive after mode switch", e0, 16'h00FF);

        summary();
        $finish;
    end
endmodule